// File: doc/BRIEF.md
# Bus-master DMA channel register front end

This block holds the registers that host software uses to steer one bus-master DMA channel. It holds a command byte, a status byte and a 32-bit descriptor-table pointer, all reached over a simple register bus with per-byte lane enables. When software changes the start bit, the block sends a one-cycle start or stop strobe to the DMA engine. It also keeps the working descriptor pointer that the engine begins from. The device interrupt passes through this block on its way to the host, and its rising edge is latched into the status byte.

Register map on the bus, by word index `reg_addr`. Word 0 holds the command byte in lane 0: bit 0 is start and bit 3 is direction. The same word holds the status byte in lane 2: bit 16 is active, bit 17 is error and bit 18 is interrupt. Word 1 is the table pointer. Other words are unmapped.

A four-state machine tracks the channel:

- `S_IDLE`: start bit 0, active clear.
- `S_RUN`: start bit 1, active set.
- `S_HALT`: start bit 1, active clear, because the engine has finished.
- `S_DRAIN`: start bit 0, active still set, because a stop is waiting for the in-flight transfer.

The transitions are:

- IDLE→RUN on a start write, with a start strobe and a pointer reload.
- RUN→IDLE on a stop write while the engine is idle, with a stop strobe.
- RUN→DRAIN on a stop write while the engine is busy.
- RUN→HALT on `eng_finish`.
- HALT→IDLE on a stop write, with no strobe.
- DRAIN→IDLE when `eng_busy` falls, with a stop strobe.
- DRAIN→RUN on a start write, with a pointer reload and no start strobe.

Top module: `bm_regs`

## Requirements
- R1: Only command bits 0 (start) and 3 (direction) are stored, and a write reaches the command byte only when byte enable 0 is set. All other command bits read back as zero, and `eng_dir_o` follows stored bit 3.
- R2: A command write whose start bit equals the stored start bit causes no strobe and no change of the active bit.
- R3: When the start bit changes from 0 to 1, the working pointer `work_ptr_o` is reloaded from the table pointer. If active (bit 16) was clear, active is set and `eng_start_o` pulses for one cycle. If active was still set because a stop was pending, no start strobe is sent.
- R4: When the start bit changes from 1 to 0 with active set and `eng_busy` low, active is cleared and `eng_stop_o` pulses for one cycle.
- R5: When the start bit changes from 1 to 0 while `eng_busy` is high, active stays set. Active is cleared, and the stop strobe is sent, in the cycle after `eng_busy` is seen low.
- R6: A pulse on `eng_finish` clears active and leaves the start bit at 1. A later write that clears the start bit sends no stop strobe.
- R7: Table-pointer writes update only the enabled byte lanes, and pointer bits 1:0 are always zero.
- R8: A read returns, in the cycle after the request, the enabled byte lanes of the addressed word, with zero in the disabled lanes.
- R9: A rising `dev_irq` sets the interrupt bit (bit 18) and raises `host_irq`. A falling `dev_irq` lowers `host_irq` and leaves the bit set.
- R10: A pulse on `eng_error` sets the error bit (bit 17). Writing 1 to bit 17 or bit 18 in lane 2 clears that bit. Writing 0 there has no effect, and bit 16 cannot be written.
- R11: Reset clears the command, status, table pointer and working pointer registers and all strobes.
- R12: Writes to unmapped words change nothing, and reads of unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word index |
| reg_be | input | BUS_W/8 | Byte lane enables |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data, registered |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_finish | input | 1 | Engine reached end of table |
| eng_error | input | 1 | Engine reports an error |
| eng_start_o | output | 1 | One-cycle start strobe |
| eng_stop_o | output | 1 | One-cycle stop strobe |
| eng_dir_o | output | 1 | Stored direction bit |
| work_ptr_o | output | BUS_W | Working descriptor pointer |
| dev_irq | input | 1 | Device interrupt level |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
The bench builds the block with its defaults: BUS_W = 32, ADDR_W = 2 and PTR_ALIGN = 2. The 2-bit word index brings words 2 and 3 within reach, so the bench can check that unmapped accesses are harmless. The 32-bit bus lets partial-lane pointer writes and reads land on every byte. Holding `eng_busy` high across a stop write drives the machine through DRAIN. From there the bench tests both exits: the busy line falling, and a restart before it falls.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_HALT  = 2'd2,
        S_DRAIN = 2'd3
    } bm_state_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int CMD_LANE      = 0;
    localparam int STAT_LANE     = 2;
    localparam int ST_ACT_BIT    = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_INT_BIT    = 2;
endpackage

// File: rtl/bm_ptr_reg.sv
module bm_ptr_reg #(
    parameter int BUS_W     = 32,
    parameter int PTR_ALIGN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BUS_W/8-1:0] be,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   ptr
);
    localparam int LANES = BUS_W / 8;
    localparam logic [BUS_W-1:0] KEEP = ~((BUS_W'(1) << PTR_ALIGN) - BUS_W'(1));

    logic [BUS_W-1:0] ptr_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[8*i +: 8] <= 8'h00;
            end else if (wr_en && be[i]) begin
                ptr_q[8*i +: 8] <= wdata[8*i +: 8] & KEEP[8*i +: 8];
            end
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/bm_cmd_fsm.sv
module bm_cmd_fsm
    import bm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_we,
    input  logic      wr_start,
    input  logic      eng_busy,
    input  logic      eng_finish,
    output bm_state_e state,
    output logic      active,
    output logic      start_bit,
    output logic      reload,
    output logic      start_pulse,
    output logic      stop_pulse
);
    bm_state_e state_q, state_d;
    logic      start_d, stop_d, start_q, stop_q;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        stop_d  = 1'b0;
        reload  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_we && wr_start) begin
                    state_d = S_RUN;
                    start_d = 1'b1;
                    reload  = 1'b1;
                end
            end
            S_RUN: begin
                if (cmd_we && !wr_start) begin
                    if (eng_busy) begin
                        state_d = S_DRAIN;
                    end else begin
                        state_d = S_IDLE;
                        stop_d  = 1'b1;
                    end
                end else if (eng_finish) begin
                    state_d = S_HALT;
                end
            end
            S_HALT: begin
                if (cmd_we && !wr_start) begin
                    state_d = S_IDLE;
                end
            end
            S_DRAIN: begin
                if (cmd_we && wr_start) begin
                    state_d = S_RUN;
                    reload  = 1'b1;
                end else if (!eng_busy) begin
                    state_d = S_IDLE;
                    stop_d  = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= start_d;
            stop_q  <= stop_d;
        end
    end

    assign state       = state_q;
    assign active      = (state_q == S_RUN) || (state_q == S_DRAIN);
    assign start_bit   = (state_q == S_RUN) || (state_q == S_HALT);
    assign start_pulse = start_q;
    assign stop_pulse  = stop_q;
endmodule

// File: rtl/bm_irq_status.sv
module bm_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_irq,
    input  logic eng_error,
    input  logic clr_err,
    input  logic clr_int,
    output logic err_bit,
    output logic int_bit,
    output logic host_irq
);
    logic irq_q, err_q, int_q;
    logic irq_rise;

    assign irq_rise = dev_irq && !irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
            int_q <= 1'b0;
        end else begin
            irq_q <= dev_irq;
            if (eng_error) begin
                err_q <= 1'b1;
            end else if (clr_err) begin
                err_q <= 1'b0;
            end
            if (irq_rise) begin
                int_q <= 1'b1;
            end else if (clr_int) begin
                int_q <= 1'b0;
            end
        end
    end

    assign err_bit  = err_q;
    assign int_bit  = int_q;
    assign host_irq = irq_q;
endmodule

// File: rtl/bm_regs.sv
module bm_regs
    import bm_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 2,
    parameter int CMD_WORD  = 0,
    parameter int PTR_WORD  = 1,
    parameter int PTR_ALIGN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BUS_W/8-1:0] reg_be,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [BUS_W-1:0]   reg_rdata,
    input  logic               eng_busy,
    input  logic               eng_finish,
    input  logic               eng_error,
    output logic               eng_start_o,
    output logic               eng_stop_o,
    output logic               eng_dir_o,
    output logic [BUS_W-1:0]   work_ptr_o,
    input  logic               dev_irq,
    output logic               host_irq
);
    localparam int LANES = BUS_W / 8;
    localparam int ST_ERR_POS = 8 * STAT_LANE + ST_ERR_BIT;
    localparam int ST_INT_POS = 8 * STAT_LANE + ST_INT_BIT;

    logic             hit_cmd, hit_ptr, do_wr, do_rd;
    logic             cmd_we, ptr_we, st_we;
    logic             act_bit, start_bit, reload, err_bit, int_bit;
    logic             dir_q;
    logic [BUS_W-1:0] ptr_q, work_q, rd_q, word_sel, rd_d;
    logic [7:0]       cmd_byte, stat_byte;
    bm_state_e        fsm_state;

    assign do_wr   = reg_valid && reg_write;
    assign do_rd   = reg_valid && !reg_write;
    assign hit_cmd = (reg_addr == ADDR_W'(CMD_WORD));
    assign hit_ptr = (reg_addr == ADDR_W'(PTR_WORD));
    assign cmd_we  = do_wr && hit_cmd && reg_be[CMD_LANE];
    assign st_we   = do_wr && hit_cmd && reg_be[STAT_LANE];
    assign ptr_we  = do_wr && hit_ptr;

    bm_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .wr_start    (reg_wdata[CMD_START_BIT]),
        .eng_busy    (eng_busy),
        .eng_finish  (eng_finish),
        .state       (fsm_state),
        .active      (act_bit),
        .start_bit   (start_bit),
        .reload      (reload),
        .start_pulse (eng_start_o),
        .stop_pulse  (eng_stop_o)
    );

    bm_ptr_reg #(.BUS_W(BUS_W), .PTR_ALIGN(PTR_ALIGN)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ptr_we),
        .be    (reg_be),
        .wdata (reg_wdata),
        .ptr   (ptr_q)
    );

    bm_irq_status u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .eng_error (eng_error),
        .clr_err   (st_we && reg_wdata[ST_ERR_POS]),
        .clr_int   (st_we && reg_wdata[ST_INT_POS]),
        .err_bit   (err_bit),
        .int_bit   (int_bit),
        .host_irq  (host_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            work_q <= '0;
        end else begin
            if (cmd_we) begin
                dir_q <= reg_wdata[CMD_DIR_BIT];
            end
            if (reload) begin
                work_q <= ptr_q;
            end
        end
    end

    always_comb begin
        cmd_byte = 8'h00;
        cmd_byte[CMD_START_BIT] = start_bit;
        cmd_byte[CMD_DIR_BIT]   = dir_q;
        stat_byte = 8'h00;
        stat_byte[ST_ACT_BIT] = act_bit;
        stat_byte[ST_ERR_BIT] = err_bit;
        stat_byte[ST_INT_BIT] = int_bit;
        word_sel = '0;
        if (hit_cmd) begin
            word_sel[8*CMD_LANE +: 8]  = cmd_byte;
            word_sel[8*STAT_LANE +: 8] = stat_byte;
        end else if (hit_ptr) begin
            word_sel = ptr_q;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd_lane
        assign rd_d[8*i +: 8] = reg_be[i] ? word_sel[8*i +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (do_rd) begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata  = rd_q;
    assign eng_dir_o  = dir_q;
    assign work_ptr_o = work_q;
endmodule

// File: rtl/bm_regs_chk.sv
module bm_regs_chk #(
    parameter int BUS_W     = 32,
    parameter int PTR_ALIGN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_o,
    input logic             stop_o,
    input logic             busy,
    input logic             finish,
    input logic             act,
    input logic             dev_irq,
    input logic             host_irq,
    input logic             int_bit,
    input logic [BUS_W-1:0] work_ptr
);
    // R3
    start_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> act);

    // R4
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o}));

    // R5
    stop_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!$past(busy) && !act));

    // R5
    drain_holds_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && busy && !finish) |=> act);

    // R9
    irq_edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_irq) |=> (int_bit && host_irq));

    // R7
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        work_ptr[PTR_ALIGN-1:0] == '0);
endmodule

bind bm_regs bm_regs_chk #(.BUS_W(BUS_W), .PTR_ALIGN(PTR_ALIGN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_o  (eng_start_o),
    .stop_o   (eng_stop_o),
    .busy     (eng_busy),
    .finish   (eng_finish),
    .act      (act_bit),
    .dev_irq  (dev_irq),
    .host_irq (host_irq),
    .int_bit  (int_bit),
    .work_ptr (work_ptr_o)
);

// File: tb/bm_regs_test.sv
module bm_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0, eng_finish = 1'b0, eng_error = 1'b0;
    logic        eng_start_o, eng_stop_o, eng_dir_o;
    logic [31:0] work_ptr_o;
    logic        dev_irq = 1'b0, host_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bm_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .eng_busy(eng_busy), .eng_finish(eng_finish),
        .eng_error(eng_error), .eng_start_o(eng_start_o), .eng_stop_o(eng_stop_o),
        .eng_dir_o(eng_dir_o), .work_ptr_o(work_ptr_o), .dev_irq(dev_irq),
        .host_irq(host_irq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [1:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_start;
        logic        exp_stop;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{4'd7,  1'b1, 2'd1, 4'b1111, 32'h1234_5677, 32'h0,          1'b0, 1'b0},
        '{4'd7,  1'b0, 2'd1, 4'b1111, 32'h0,         32'h1234_5674,  1'b0, 1'b0},
        '{4'd7,  1'b1, 2'd1, 4'b0010, 32'h0000_AB00, 32'h0,          1'b0, 1'b0},
        '{4'd8,  1'b0, 2'd1, 4'b0110, 32'h0,         32'h0034_AB00,  1'b0, 1'b0},
        '{4'd8,  1'b0, 2'd1, 4'b1000, 32'h0,         32'h1200_0000,  1'b0, 1'b0},
        '{4'd3,  1'b1, 2'd0, 4'b0001, 32'h0000_00FF, 32'h0,          1'b1, 1'b0},
        '{4'd1,  1'b0, 2'd0, 4'b0101, 32'h0,         32'h0001_0009,  1'b0, 1'b0},
        '{4'd2,  1'b1, 2'd0, 4'b0001, 32'h0000_0009, 32'h0,          1'b0, 1'b0},
        '{4'd2,  1'b1, 2'd0, 4'b0001, 32'h0000_0001, 32'h0,          1'b0, 1'b0},
        '{4'd1,  1'b0, 2'd0, 4'b0001, 32'h0,         32'h0000_0001,  1'b0, 1'b0},
        '{4'd4,  1'b1, 2'd0, 4'b0001, 32'h0000_0000, 32'h0,          1'b0, 1'b1},
        '{4'd4,  1'b0, 2'd0, 4'b0101, 32'h0,         32'h0000_0000,  1'b0, 1'b0},
        '{4'd2,  1'b1, 2'd0, 4'b0001, 32'h0000_0000, 32'h0,          1'b0, 1'b0},
        '{4'd12, 1'b1, 2'd2, 4'b1111, 32'hFFFF_FFFF, 32'h0,          1'b0, 1'b0},
        '{4'd12, 1'b0, 2'd2, 4'b1111, 32'h0,         32'h0000_0000,  1'b0, 1'b0},
        '{4'd12, 1'b0, 2'd1, 4'b1111, 32'h0,         32'h1234_AB74,  1'b0, 1'b0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd7:  return "R7";
            4'd8:  return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [3:0] be, input logic [31:0] exp);
        acc(1'b0, a, be, 32'h0);
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", {eng_start_o, eng_stop_o, host_irq, eng_dir_o}, 32'h0);
        check("R11", work_ptr_o, 32'h0);
        rd_chk("R11", 2'd0, 4'b1111, 32'h0);
        rd_chk("R11", 2'd1, 4'b1111, 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(TBL[i].wr, TBL[i].addr, TBL[i].be, TBL[i].wdata);
            if (!TBL[i].wr) check(req_name(TBL[i].req), reg_rdata, TBL[i].exp_rd);
            check(req_name(TBL[i].req), {30'h0, eng_start_o, eng_stop_o},
                  {30'h0, TBL[i].exp_start, TBL[i].exp_stop});
        end

        // R3 reload happens only on the start edge
        acc(1'b1, 2'd1, 4'b1111, 32'hA000_0003);
        check("R3", work_ptr_o, 32'h1234_AB74);
        acc(1'b1, 2'd0, 4'b0001, 32'h0000_0001);
        check("R3", {31'h0, eng_start_o}, 32'h1);
        check("R3", work_ptr_o, 32'hA000_0000);
        check("R1", {31'h0, eng_dir_o}, 32'h0);

        // R5 stop deferred while busy
        eng_busy = 1'b1;
        acc(1'b1, 2'd0, 4'b0001, 32'h0);
        check("R5", {31'h0, eng_stop_o}, 32'h0);
        rd_chk("R5", 2'd0, 4'b0101, 32'h0001_0000);
        @(negedge clk); eng_busy = 1'b0;
        @(negedge clk);
        check("R5", {31'h0, eng_stop_o}, 32'h1);
        rd_chk("R5", 2'd0, 4'b0101, 32'h0);

        // R3 restart while draining: reload, no start strobe
        eng_busy = 1'b1;
        acc(1'b1, 2'd0, 4'b0001, 32'h0000_0001);
        check("R3", {31'h0, eng_start_o}, 32'h1);
        acc(1'b1, 2'd1, 4'b1111, 32'h0000_1000);
        acc(1'b1, 2'd0, 4'b0001, 32'h0);
        acc(1'b1, 2'd0, 4'b0001, 32'h0000_0009);
        check("R3", {31'h0, eng_start_o}, 32'h0);
        check("R3", work_ptr_o, 32'h0000_1000);
        check("R1", {31'h0, eng_dir_o}, 32'h1);
        @(negedge clk); eng_busy = 1'b0;
        @(negedge clk);
        check("R3", {31'h0, eng_stop_o}, 32'h0);
        rd_chk("R3", 2'd0, 4'b0101, 32'h0001_0009);

        // R6 engine finish
        pulse(eng_finish);
        rd_chk("R6", 2'd0, 4'b0101, 32'h0000_0009);
        acc(1'b1, 2'd0, 4'b0001, 32'h0000_0001);
        check("R6", {30'h0, eng_start_o, eng_stop_o}, 32'h0);
        acc(1'b1, 2'd0, 4'b0001, 32'h0);
        check("R6", {30'h0, eng_start_o, eng_stop_o}, 32'h0);
        rd_chk("R6", 2'd0, 4'b0101, 32'h0);

        // R9 interrupt edge
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk);
        check("R9", {31'h0, host_irq}, 32'h1);
        rd_chk("R9", 2'd0, 4'b0100, 32'h0004_0000);
        @(negedge clk); dev_irq = 1'b0;
        @(negedge clk);
        check("R9", {31'h0, host_irq}, 32'h0);
        rd_chk("R9", 2'd0, 4'b0100, 32'h0004_0000);

        // R10 write-one-to-clear
        acc(1'b1, 2'd0, 4'b0100, 32'h0);
        rd_chk("R10", 2'd0, 4'b0100, 32'h0004_0000);
        acc(1'b1, 2'd0, 4'b0100, 32'h0007_0000);
        rd_chk("R10", 2'd0, 4'b0100, 32'h0);
        pulse(eng_error);
        rd_chk("R10", 2'd0, 4'b0100, 32'h0002_0000);
        acc(1'b1, 2'd0, 4'b0100, 32'h0004_0000);
        rd_chk("R10", 2'd0, 4'b0100, 32'h0002_0000);
        acc(1'b1, 2'd0, 4'b0100, 32'h0002_0000);
        rd_chk("R10", 2'd0, 4'b0100, 32'h0);
        acc(1'b1, 2'd0, 4'b0001, 32'h0000_0001);
        acc(1'b1, 2'd0, 4'b0100, 32'h0001_0000);
        rd_chk("R10", 2'd0, 4'b0101, 32'h0001_0001);
        acc(1'b1, 2'd0, 4'b0001, 32'h0);
        check("R4", {31'h0, eng_stop_o}, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule